// File: doc/BRIEF.md
# Tiled Word RAM with Row Decode

This block is a word-addressed random access memory assembled from a grid of identical small storage tiles. Tiles are arranged in rows and lanes. The upper address bits pick one row through a one-hot decoder; the lower address bits go to every tile, along with the write data and the write strobe. The tiles within a row sit side by side. Each tile holds one slice of the full word. The tile in lane 0 holds the most significant slice.

A single select input and a single write strobe define the operation. With select low, the memory is idle. With select high and the strobe low, it reads combinationally from the current address. With select high and the strobe high, it writes on the rising clock edge. The read bus is a one-hot AND-OR mux, not a shared three-state line. It carries zero whenever no read is in progress. The decoded row vector is brought out as a port so that the row decode can be observed.

Top module: `tiled_word_ram`

## Requirements
- R1: With `cs`=0 no operation takes place whatever `wr` is: `row_sel` is all zeros, `rdata` is zero, and no stored word changes.
- R2: With `cs`=1, `row_sel` has exactly one bit set, and that bit's index equals the value of the top ROW_BITS address bits (`addr[ADDR_W-1:TILE_AW]`).
- R3: With `cs`=1 and `wr`=1, the word on `wdata` is stored on the rising clock edge at row `addr[ADDR_W-1:TILE_AW]`, offset `addr[TILE_AW-1:0]`.
- R4: With `cs`=1 and `wr`=0, `rdata` shows the stored word at `addr` in the same cycle, and it follows a change of `addr` without waiting for a clock edge.
- R5: Words at the same low offset in different rows are independent: a write to one row leaves the same offset in every other row unchanged.
- R6: While a write is in progress (`cs`=1, `wr`=1), `rdata` is zero.
- R7: During a read, `wdata` is ignored: no stored word changes, whatever value `wdata` carries.
- R8: All DATA_W = LANES*LANE_W bits of a word are stored and returned. Each lane slice keeps its own value, so words whose lanes differ come back intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes occur on its rising edge |
| cs | input | 1 | Memory select; 0 means idle |
| wr | input | 1 | 1 = write, 0 = read, when selected |
| addr | input | ADDR_W | Word address; the top ROW_BITS pick the row |
| wdata | input | DATA_W | Word to store |
| rdata | output | DATA_W | Word read; zero when no read is active |
| row_sel | output | ROWS | One-hot decoded row enable |

## Verification
The bench puts a distinct pattern at the same low offset in every row. If the row bits were dropped or decoded wrongly, the rows would alias: the last pattern written would show up everywhere, or the wrong row would come back. Writes attempted with select low, and reads made while `wdata` is toggling, are followed by read-back. A design that let either one reach a tile would show a corrupted word. Lane patterns in which the high and low bytes differ would expose a swapped or short lane slice. Changing the address mid-cycle during a read would expose a registered read path, because `rdata` would lag by one cycle.

// File: rtl/tiled_ram_pkg.sv
package tiled_ram_pkg;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } ram_op_e;

  function automatic ram_op_e op_of(input logic sel, input logic strobe);
    if (!sel)       return OP_IDLE;
    else if (strobe) return OP_WRITE;
    else            return OP_READ;
  endfunction

  // upper bit index of lane l; lane 0 holds the most significant slice
  function automatic int lane_hi(input int l, input int lanes, input int lane_w);
    return (lanes - l) * lane_w - 1;
  endfunction

endpackage

// File: rtl/tile_row_decoder.sv
module tile_row_decoder #(
  parameter int ROWS     = 4,
  parameter int ROW_BITS = $clog2(ROWS)
) (
  input  logic                en,
  input  logic [ROW_BITS-1:0] idx,
  output logic [ROWS-1:0]     sel
);
  for (genvar r = 0; r < ROWS; r++) begin : g_out
    assign sel[r] = en && (idx == ROW_BITS'(r));
  end
endmodule

// File: rtl/ram_tile.sv
module ram_tile #(
  parameter int AW = 4,
  parameter int W  = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/onehot_word_mux.sv
module onehot_word_mux #(
  parameter int N = 4,
  parameter int W = 16
) (
  input  logic [N-1:0]        sel,
  input  logic [N-1:0][W-1:0] din,
  output logic [W-1:0]        dout
);
  always_comb begin
    dout = '0;
    for (int i = 0; i < N; i++) begin
      dout = dout | ({W{sel[i]}} & din[i]);
    end
  end
endmodule

// File: rtl/tiled_word_ram.sv
module tiled_word_ram #(
  parameter int TILE_AW = 4,
  parameter int LANE_W  = 8,
  parameter int ROWS    = 4,
  parameter int LANES   = 2,
  localparam int ROW_BITS = $clog2(ROWS),
  localparam int ADDR_W   = TILE_AW + ROW_BITS,
  localparam int DATA_W   = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              cs,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [ROWS-1:0]   row_sel
);
  import tiled_ram_pkg::*;

  ram_op_e               op;
  logic                  op_write;
  logic                  op_read;
  logic [ROW_BITS-1:0]   row_idx;
  logic [TILE_AW-1:0]    tile_addr;
  logic [ROWS-1:0]       rd_sel;
  logic [ROWS-1:0][DATA_W-1:0] row_word;

  assign op        = op_of(cs, wr);
  assign op_write  = (op == OP_WRITE);
  assign op_read   = (op == OP_READ);
  assign row_idx   = addr[ADDR_W-1:TILE_AW];
  assign tile_addr = addr[TILE_AW-1:0];

  tile_row_decoder #(.ROWS(ROWS), .ROW_BITS(ROW_BITS)) u_dec (
    .en  (cs),
    .idx (row_idx),
    .sel (row_sel)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      localparam int HI = lane_hi(l, LANES, LANE_W);
      ram_tile #(.AW(TILE_AW), .W(LANE_W)) u_tile (
        .clk   (clk),
        .we    (op_write && row_sel[r]),
        .addr  (tile_addr),
        .wdata (wdata[HI -: LANE_W]),
        .rdata (row_word[r][HI -: LANE_W])
      );
    end
  end

  assign rd_sel = row_sel & {ROWS{op_read}};

  onehot_word_mux #(.N(ROWS), .W(DATA_W)) u_mux (
    .sel  (rd_sel),
    .din  (row_word),
    .dout (rdata)
  );
endmodule

// File: rtl/tiled_word_ram_chk.sv
module tiled_word_ram_chk #(
  parameter int ROWS     = 4,
  parameter int TILE_AW  = 4,
  parameter int ADDR_W   = 6,
  parameter int DATA_W   = 16
) (
  input logic              clk,
  input logic              cs,
  input logic              wr,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic [DATA_W-1:0] rdata,
  input logic [ROWS-1:0]   row_sel
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  p_idle_r1: assert property (@(posedge clk) disable iff (!armed)
    !cs |-> (row_sel == '0 && rdata == '0));

  p_onehot_r2: assert property (@(posedge clk) disable iff (!armed)
    cs |-> ($countones(row_sel) == 1));

  p_row_match_r2: assert property (@(posedge clk) disable iff (!armed)
    cs |-> row_sel[addr[ADDR_W-1:TILE_AW]]);

  p_write_readback_r3: assert property (@(posedge clk) disable iff (!armed)
    (cs && wr) |=> ((cs && !wr && addr == $past(addr)) ? (rdata == $past(wdata)) : 1'b1));

  p_write_quiet_r6: assert property (@(posedge clk) disable iff (!armed)
    (cs && wr) |-> (rdata == '0));

  p_read_hold_r7: assert property (@(posedge clk) disable iff (!armed)
    (cs && !wr) |=> ((cs && !wr && $stable(addr)) ? $stable(rdata) : 1'b1));
endmodule

bind tiled_word_ram tiled_word_ram_chk #(
  .ROWS(ROWS), .TILE_AW(TILE_AW), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk(clk), .cs(cs), .wr(wr), .addr(addr),
  .wdata(wdata), .rdata(rdata), .row_sel(row_sel)
);

// File: tb/sim_tiled_word_ram.sv
`timescale 1ns/1ps
module sim_tiled_word_ram;
  localparam int TILE_AW = 4;
  localparam int LANE_W  = 8;
  localparam int ROWS    = 4;
  localparam int LANES   = 2;
  localparam int RB      = 2;
  localparam int AW      = TILE_AW + RB;
  localparam int DW      = LANES * LANE_W;

  logic          clk = 1'b0;
  logic          cs = 1'b0;
  logic          wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [DW-1:0] rdata;
  logic [ROWS-1:0] row_sel;

  int checks = 0;
  int failures = 0;
  logic [DW-1:0] model [1 << AW];

  always #4 clk = ~clk;

  tiled_word_ram #(.TILE_AW(TILE_AW), .LANE_W(LANE_W), .ROWS(ROWS), .LANES(LANES)) u0 (
    .clk(clk), .cs(cs), .wr(wr), .addr(addr),
    .wdata(wdata), .rdata(rdata), .row_sel(row_sel)
  );

  function automatic logic [AW-1:0] mk_addr(input int row, input int off);
    return AW'(row * (1 << TILE_AW) + off);
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    #1;
    check("R6 rdata zero in write", rdata, '0);
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    model[a] = d;
  endtask

  task automatic read_check(input string req, input logic [AW-1:0] a);
    @(negedge clk);
    cs = 1'b1; wr = 1'b0; addr = a;
    #1;
    check(req, rdata, model[a]);
    cs = 1'b0;
  endtask

  task automatic t_idle();
    @(negedge clk);
    cs = 1'b0; wr = 1'b0; addr = mk_addr(3, 5);
    #1;
    check("R1 row_sel idle", DW'(row_sel), '0);
    check("R1 rdata idle", rdata, '0);
  endtask

  task automatic t_no_alias();
    for (int r = 0; r < ROWS; r++) do_write(mk_addr(r, 7), DW'(16'hC300 + r * 16'h1111));
    for (int r = 0; r < ROWS; r++) read_check("R5 same offset per row", mk_addr(r, 7));
    do_write(mk_addr(2, 7), 16'h0F0F);
    for (int r = 0; r < ROWS; r++) read_check("R5 after rewrite row 2", mk_addr(r, 7));
    read_check("R3 stored word", mk_addr(0, 7));
  endtask

  task automatic t_decode();
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      cs = 1'b1; wr = r[0]; addr = mk_addr(r, 3);
      wdata = model[mk_addr(r, 3)];
      #1;
      check("R2 one-hot row", DW'(row_sel), DW'(1 << r));
    end
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
  endtask

  task automatic t_cs_low_ignored();
    do_write(mk_addr(1, 9), 16'h1234);
    @(negedge clk);
    cs = 1'b0; wr = 1'b1; addr = mk_addr(1, 9); wdata = 16'hDEAD;
    @(negedge clk);
    @(negedge clk);
    wr = 1'b0;
    read_check("R1 write with cs low ignored", mk_addr(1, 9));
  endtask

  task automatic t_read_ignores_wdata();
    do_write(mk_addr(3, 2), 16'h5AA5);
    @(negedge clk);
    cs = 1'b1; wr = 1'b0; addr = mk_addr(3, 2); wdata = 16'hFFFF;
    @(negedge clk);
    wdata = 16'h0000;
    @(negedge clk);
    cs = 1'b0;
    read_check("R7 read leaves word", mk_addr(3, 2));
  endtask

  task automatic t_comb_read();
    do_write(mk_addr(0, 1), 16'hAB01);
    do_write(mk_addr(2, 14), 16'h02CD);
    @(negedge clk);
    cs = 1'b1; wr = 1'b0; addr = mk_addr(0, 1);
    #1;
    check("R4 read same cycle", rdata, 16'hAB01);
    addr = mk_addr(2, 14);
    #1;
    check("R4 follows addr mid-cycle", rdata, 16'h02CD);
    cs = 1'b0;
  endtask

  task automatic t_lanes();
    do_write(mk_addr(1, 0), 16'hFF00);
    do_write(mk_addr(1, 15), 16'h00FF);
    do_write(mk_addr(3, 15), 16'h8001);
    read_check("R8 high lane only", mk_addr(1, 0));
    read_check("R8 low lane only", mk_addr(1, 15));
    read_check("R8 edge bits", mk_addr(3, 15));
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) model[i] = '0;
    repeat (2) @(negedge clk);
    t_idle();
    t_no_alias();
    t_decode();
    t_cs_low_ignored();
    t_read_ignores_wdata();
    t_comb_read();
    t_lanes();
    t_idle();
    finish_up();
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_up();
  end
endmodule